// File: doc/BRIEF.md
# Wear-Aware Byte Write Controller

This block sits between a single-byte write request port and a byte-addressable non-volatile cell array. The array has two separate byte operations. An erase drives every bit of a byte to 1. A program can only pull selected bits to 0. Each operation finishes after a fixed, parameterised number of clock cycles. Every array location starts out erased after reset.

For each accepted request, the controller first reads the stored byte and compares it with the requested value. It then issues only the operations that this pair of bytes needs: none, a program alone, an erase alone, or an erase followed by a program. Skipping operations that are not needed spares the cells from wear.

A request is taken only while the block is idle. A busy flag covers the whole sequence. A one-cycle done pulse marks the end, together with a 2-bit outcome code.

Top module: `ee_write_ctrl`

## Requirements
- R1: After reset, busy_o, done_o and status_o are all 0, and every array byte holds all ones.
- R2: When the stored byte equals the requested byte, no array operation is issued, and the request completes with status 2'b00 (skipped).
- R3: When the requested byte is all ones and differs from the stored byte, only an erase is issued, and the status is 2'b10 (erase only).
- R4: When (stored AND requested) equals requested and the two bytes differ, only a program is issued, and the status is 2'b01 (program only).
- R5: In every other differing case, an erase is issued and a program follows it directly, and the status is 2'b11 (erase then program).
- R6: An erase leaves the byte at all ones. A program leaves it at (old AND requested). After any completed request, the stored byte equals the requested byte, so repeating the same write returns status 2'b00.
- R7: A request is accepted on a rising edge while busy_o is low. busy_o is high from the cycle after acceptance until the cycle in which done_o rises, and in that cycle it is low. Requests presented while busy_o is high are ignored and change no byte.
- R8: Each array operation takes OP_LAT cycles. done_o is high in the cycle after rising edge 1 + n*OP_LAT, counted from the acceptance edge, where n is the number of operations issued.
- R9: done_o is a single-cycle pulse. status_o holds the outcome of the last completed request until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write request, sampled while idle |
| addr_i | input | ADDR_W | Target byte address |
| data_i | input | DATA_W | Requested byte value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Outcome: 00 skip, 01 program, 10 erase, 11 erase+program |

## Verification
The read-and-decide step takes one edge after acceptance, and each array operation adds OP_LAT edges. A skipped write therefore completes after 1 edge, a single operation after 1+OP_LAT edges, and erase plus program after 1+2*OP_LAT edges. The bench counts rising edges from the acceptance edge and samples on falling edges. It requires busy_o high on every sampled cycle before done_o and low in the done cycle, then compares the edge count with the figure for the expected outcome. Stored contents are checked only through the ports: repeating a write must report a skip, and a request injected while busy must leave its target byte still erased.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [1:0] {
    ST_SKIP  = 2'b00,
    ST_PROG  = 2'b01,
    ST_ERASE = 2'b10,
    ST_BOTH  = 2'b11
  } ee_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_READ,
    S_ERASE,
    S_PROG
  } ee_state_e;
endpackage

// File: rtl/ee_plan.sv
module ee_plan
  import ee_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] stored_i,
  input  logic [DATA_W-1:0] want_i,
  output logic              need_er_o,
  output logic              need_pg_o,
  output ee_status_e        status_o
);
  localparam logic [DATA_W-1:0] ONES = '1;

  always_comb begin
    need_er_o = 1'b0;
    need_pg_o = 1'b0;
    status_o  = ST_SKIP;
    if (stored_i != want_i) begin
      if (want_i == ONES) begin
        need_er_o = 1'b1;
        status_o  = ST_ERASE;
      end else if ((stored_i & want_i) == want_i) begin
        need_pg_o = 1'b1;
        status_o  = ST_PROG;
      end else begin
        need_er_o = 1'b1;
        need_pg_o = 1'b1;
        status_o  = ST_BOTH;
      end
    end
  end
endmodule

// File: rtl/ee_cell_array.sv
module ee_cell_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int OP_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              op_start_i,
  input  logic              op_erase_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  output logic              op_done_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(OP_LAT + 1);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              act_q, erase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign rd_data_o = mem_q[rd_addr_i];
  assign op_done_o = act_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ONES;
      act_q   <= 1'b0;
      erase_q <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (act_q) begin
        if (cnt_q == '0) begin
          act_q <= 1'b0;
          mem_q[addr_q] <= erase_q ? ONES : (mem_q[addr_q] & data_q);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      // a new start may chain directly on the completing edge
      if (op_start_i) begin
        act_q   <= 1'b1;
        erase_q <= op_erase_i;
        cnt_q   <= CNT_W'(OP_LAT - 1);
        addr_q  <= op_addr_i;
        data_q  <= op_data_i;
      end
    end
  end

  p_erase_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_o && erase_q) |=> (mem_q[$past(addr_q)] == ONES));

  p_prog_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_o && !erase_q) |=> (mem_q[$past(addr_q)] == $past(mem_q[addr_q] & data_q)));

  p_no_overlap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i |-> (!act_q || op_done_o));
endmodule

// File: rtl/ee_seq.sv
module ee_seq
  import ee_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              need_er_i,
  input  logic              need_pg_i,
  input  ee_status_e        plan_i,
  input  logic              op_done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              op_start_o,
  output logic              op_erase_o,
  output logic              busy_o,
  output logic              done_o,
  output ee_status_e        status_o
);
  ee_state_e  state_q;
  logic       need_pg_q;
  ee_status_e plan_q;

  assign busy_o = (state_q != S_IDLE);

  always_comb begin
    op_start_o = 1'b0;
    op_erase_o = 1'b0;
    unique case (state_q)
      S_READ: begin
        op_start_o = need_er_i | need_pg_i;
        op_erase_o = need_er_i;
      end
      S_ERASE: op_start_o = op_done_i && need_pg_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      addr_o    <= '0;
      data_o    <= '0;
      need_pg_q <= 1'b0;
      plan_q    <= ST_SKIP;
      done_o    <= 1'b0;
      status_o  <= ST_SKIP;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_i) begin
          addr_o  <= addr_i;
          data_o  <= data_i;
          state_q <= S_READ;
        end
        S_READ: begin
          need_pg_q <= need_pg_i;
          plan_q    <= plan_i;
          if (need_er_i)      state_q <= S_ERASE;
          else if (need_pg_i) state_q <= S_PROG;
          else begin
            done_o   <= 1'b1;
            status_o <= ST_SKIP;
            state_q  <= S_IDLE;
          end
        end
        S_ERASE: if (op_done_i) begin
          if (need_pg_q) state_q <= S_PROG;
          else begin
            done_o   <= 1'b1;
            status_o <= plan_q;
            state_q  <= S_IDLE;
          end
        end
        S_PROG: if (op_done_i) begin
          done_o   <= 1'b1;
          status_o <= plan_q;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ops_only_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> busy_o);

  p_prog_after_erase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ERASE && op_done_i && need_pg_q) |-> (op_start_o && !op_erase_o));

  p_status_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (!done_o || 1'b1) && ($stable(status_o) || done_o));
endmodule

// File: rtl/ee_write_ctrl.sv
module ee_write_ctrl
  import ee_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int OP_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data, stored;
  logic              need_er, need_pg, op_start, op_erase, op_done;
  ee_status_e        plan, status;

  ee_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_LAT(OP_LAT)) u_array (
    .clk_i, .rst_ni,
    .rd_addr_i (cur_addr),
    .rd_data_o (stored),
    .op_start_i(op_start),
    .op_erase_i(op_erase),
    .op_addr_i (cur_addr),
    .op_data_i (cur_data),
    .op_done_o (op_done)
  );

  ee_plan #(.DATA_W(DATA_W)) u_plan (
    .stored_i (stored),
    .want_i   (cur_data),
    .need_er_o(need_er),
    .need_pg_o(need_pg),
    .status_o (plan)
  );

  ee_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .addr_i, .data_i,
    .need_er_i (need_er),
    .need_pg_i (need_pg),
    .plan_i    (plan),
    .op_done_i (op_done),
    .addr_o    (cur_addr),
    .data_o    (cur_data),
    .op_start_o(op_start),
    .op_erase_o(op_erase),
    .busy_o,
    .done_o,
    .status_o  (status)
  );

  assign status_o = status;
endmodule

// File: tb/tb_ee_write_ctrl.sv
module tb_ee_write_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int OP_LAT = 3;
  localparam int WD_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic              busy, done;
  logic [1:0]        status;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_LAT(OP_LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .data_i(data),
    .busy_o(busy), .done_o(done), .status_o(status)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  // issues one write; optionally injects a second request while busy
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic [1:0] exp_st, input int n_ops, input string rq,
                          input bit inject = 1'b0,
                          input logic [ADDR_W-1:0] ia = '0,
                          input logic [DATA_W-1:0] id = '0);
    int  lat = 0;
    bit  busy_ok = 1'b1;
    @(negedge clk);
    req = 1'b1; addr = a; data = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    if (!busy) busy_ok = 1'b0;
    do begin
      if (inject && lat == 1) begin
        req = 1'b1; addr = ia; data = id;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      req = 1'b0;
      if (!done && !busy) busy_ok = 1'b0;
    end while (!done && lat < 200);
    chk(done, {rq, " done seen"}, int'(done), 1);
    chk(status == exp_st, {rq, " status"}, int'(status), int'(exp_st));
    chk(lat == 1 + n_ops*OP_LAT, {"R8 latency ", rq}, lat, 1 + n_ops*OP_LAT);
    chk(busy_ok && !busy, {"R7 busy window ", rq}, int'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done && status == exp_st, "R9 pulse/hold", int'({done, status}), int'(exp_st));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && status == 2'b00, "R1 reset outputs", int'({busy, done, status}), 0);
    do_write(4'd5, 8'hFF, 2'b00, 0, "R1 erased after reset R2");
  endtask

  task automatic t_program_only();
    do_write(4'd1, 8'hA5, 2'b01, 1, "R4 FF->A5");
    do_write(4'd1, 8'hA5, 2'b00, 0, "R6 R2 repeat A5");
    do_write(4'd1, 8'h25, 2'b01, 1, "R4 A5->25");
  endtask

  task automatic t_erase_only();
    do_write(4'd1, 8'hFF, 2'b10, 1, "R3 25->FF");
    do_write(4'd1, 8'hFF, 2'b00, 0, "R6 repeat FF");
  endtask

  task automatic t_both();
    do_write(4'd7, 8'h0F, 2'b01, 1, "R4 FF->0F");
    do_write(4'd7, 8'hF0, 2'b11, 2, "R5 0F->F0");
    do_write(4'd7, 8'hF0, 2'b00, 0, "R6 repeat F0");
    do_write(4'd7, 8'h81, 2'b11, 2, "R5 F0->81");
  endtask

  task automatic t_ignore_busy();
    do_write(4'd2, 8'h00, 2'b01, 1, "R7 main write", 1'b1, 4'd3, 8'h00);
    do_write(4'd3, 8'hFF, 2'b00, 0, "R7 ignored target untouched");
    do_write(4'd2, 8'h00, 2'b00, 0, "R6 repeat 00");
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", WD_CYCLES, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_program_only();
    t_erase_only();
    t_both();
    t_ignore_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule